// File: doc/BRIEF.md
# Codec Power and Clock-Mode Controller

This block decides when a PCM codec is powered and how its internal clocks are sourced, using only four control pins sampled on a fast system clock. Two of the pins carry two meanings. The receive master-clock pin powers the codec down when it is held high. When it is held low, the codec runs every internal timer from the transmit master clock. When it toggles, it is a real receive master clock. The receive bit-clock pin works the same way. When it toggles, it is a receive bit clock. When it is held at a fixed level, the transmit bit clock serves both directions and the pin's level picks the master-clock divider.

A small activity detector decides for each dual-use pin whether it is clocked or static. The detector works over fixed windows of system clocks. The power sequencer wakes the codec on a frame-sync pulse and puts it back to sleep after a programmable stretch of silence on both frame syncs. It also holds the transmit data driver off until a second transmit frame sync has been seen. A compile-time parameter selects the divider decode for the A-law part or for the mu-law part.

All pins are taken to be already synchronised to the system clock. The outputs drive the codec's clock muxes, its divider, and the enable of its data output buffer.

Top module: `codec_pwr_clk_ctl`

## Requirements
- R1: During and after reset, until a wake-up: `pwr_on`=0, `tx_drive_en`=0, `rx_mclk_from_tx`=1, `rx_bclk_from_tx`=1. `mclk_div_sel` is 0 for the A-law build and 1 for the mu-law build.
- R2: Windows of WIN_CYCLES system clocks start right after reset and run back to back. At the close of each window, a pin is classed as clocked if at least two level changes were seen during that window, and as static otherwise. The class holds until the next window closes. A static pin's level is its value registered one clock earlier.
- R3: While the power pin is static and high, the block goes to or stays in the powered-down state one clock later, and frame syncs cannot wake it.
- R4: While powered down, a rising edge on either frame sync wakes the block (`pwr_on`=1 one clock later), unless R3 applies. A sync held high for several clocks counts as a single edge.
- R5: While powered up, if IDLE_TIMEOUT clocks pass after the last sync rising edge with no new edge on either sync, `pwr_on` returns to 0.
- R6: `tx_drive_en` goes high, one clock after the second transmit sync rising edge counted from wake-up (the wake-up edge counts if it was a transmit edge). It is never high while `pwr_on` is 0.
- R7: `rx_mclk_from_tx`=1 exactly when the power pin is classed static. `rx_bclk_from_tx`=1 exactly when the select pin is classed static.
- R8: `mclk_div_sel` encoding: 1 selects the 2.048 MHz divider and 0 selects the 1.536/1.544 MHz divider. A-law build: clocked→1, static 0→0, static 1→1. Mu-law build: clocked→0, static 0→1, static 1→0.
- R9: A receive sync edge wakes the block and restarts the idle timeout, but it does not advance the transmit-driver count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_mclk_or_pd | input | 1 | Receive master clock, or power-down level when static |
| rx_bclk_or_sel | input | 1 | Receive bit clock, or divider select level when static |
| tx_sync | input | 1 | Transmit frame sync |
| rx_sync | input | 1 | Receive frame sync |
| pwr_on | output | 1 | Codec powered up |
| tx_drive_en | output | 1 | Transmit data driver permitted |
| rx_mclk_from_tx | output | 1 | Receive side uses the transmit master clock |
| rx_bclk_from_tx | output | 1 | Receive side uses the transmit bit clock |
| mclk_div_sel | output | 1 | Divider select: 1 = 2.048 MHz, 0 = 1.536/1.544 MHz |

## Verification
The bench aims at the places where the dual meaning of the pins can be misread. These include a pin toggling once per window, which must stay static, and a clocked power pin, which must never force power-down. A detector that counted over a sliding window, or that took a single transition as a clock, would flip the clock muxes and the divider at the wrong time. A faulty design could also let a static-high pin fail to hold the codec off. The bench drives long sync pulses and receive-only syncs to catch a gate that counts levels instead of edges, or that counts the wrong sync, since either fault enables the data driver a frame early. It also checks the timeout at its exact cycle, which catches an idle counter that is off by one or that is not reloaded by receive syncs.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;

    typedef enum logic {
        PWR_OFF = 1'b0,
        PWR_ON  = 1'b1
    } pwr_state_e;

    // divider select encoding driven to the codec clock generator
    localparam logic DIV_2048 = 1'b1;
    localparam logic DIV_15XX = 1'b0;

endpackage

// File: rtl/pin_activity_det.sv
module pin_activity_det #(
    parameter int WIN      = 64,
    parameter int EDGE_MIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic clocked_o,
    output logic level_o
);
    localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int EW = $clog2(EDGE_MIN + 1);

    typedef struct packed {
        logic          pin;
        logic [CW-1:0] win;
        logic [EW-1:0] edges;
        logic          clocked;
    } det_t;

    det_t det_d, det_q;
    logic          toggle;
    logic [EW-1:0] edges_sat;

    always_comb begin
        det_d     = det_q;
        toggle    = pin_i ^ det_q.pin;
        edges_sat = (det_q.edges >= EW'(EDGE_MIN)) ? det_q.edges
                                                   : det_q.edges + EW'(toggle);
        det_d.pin = pin_i;
        if (det_q.win == CW'(WIN - 1)) begin
            det_d.win     = '0;
            det_d.edges   = '0;
            det_d.clocked = (edges_sat >= EW'(EDGE_MIN));
        end else begin
            det_d.win   = det_q.win + CW'(1);
            det_d.edges = edges_sat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    assign clocked_o = det_q.clocked;
    assign level_o   = det_q.pin;

endmodule

// File: rtl/freq_sel_decode.sv
module freq_sel_decode
    import codec_ctl_pkg::*;
#(
    parameter bit LAW_A = 1'b1
) (
    input  logic clocked_i,
    input  logic level_i,
    output logic div_sel_o
);
    generate
        if (LAW_A) begin : g_alaw
            always_comb begin
                if (clocked_i)    div_sel_o = DIV_2048;
                else if (level_i) div_sel_o = DIV_2048;
                else              div_sel_o = DIV_15XX;
            end
        end else begin : g_mulaw
            always_comb begin
                if (clocked_i)    div_sel_o = DIV_15XX;
                else if (level_i) div_sel_o = DIV_15XX;
                else              div_sel_o = DIV_2048;
            end
        end
    endgenerate

endmodule

// File: rtl/power_seq.sv
module power_seq
    import codec_ctl_pkg::*;
#(
    parameter int TIMEOUT  = 100000,
    parameter int GATE_CNT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_rise_i,
    input  logic rx_rise_i,
    input  logic force_off_i,
    output logic pwr_on_o,
    output logic drive_en_o
);
    localparam int TW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam int GW = $clog2(GATE_CNT + 1);

    typedef struct packed {
        pwr_state_e    state;
        logic [TW-1:0] idle;
        logic [GW-1:0] txcnt;
        logic          drive;
    } seq_t;

    seq_t seq_d, seq_q;
    logic rise_any;

    always_comb begin
        seq_d    = seq_q;
        rise_any = tx_rise_i | rx_rise_i;
        case (seq_q.state)
            PWR_OFF: begin
                seq_d.idle = '0;
                if (rise_any && !force_off_i) begin
                    seq_d.state = PWR_ON;
                    seq_d.txcnt = tx_rise_i ? GW'(1) : '0;
                end
            end
            default: begin
                if (force_off_i) begin
                    seq_d.state = PWR_OFF;
                    seq_d.idle  = '0;
                    seq_d.txcnt = '0;
                end else if (rise_any) begin
                    seq_d.idle = '0;
                    if (tx_rise_i && (seq_q.txcnt < GW'(GATE_CNT))) begin
                        seq_d.txcnt = seq_q.txcnt + GW'(1);
                    end
                end else if (seq_q.idle == TW'(TIMEOUT - 1)) begin
                    seq_d.state = PWR_OFF;
                    seq_d.idle  = '0;
                    seq_d.txcnt = '0;
                end else begin
                    seq_d.idle = seq_q.idle + TW'(1);
                end
            end
        endcase
        seq_d.drive = (seq_d.state == PWR_ON) && (seq_d.txcnt >= GW'(GATE_CNT));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: PWR_OFF, idle: '0, txcnt: '0, drive: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pwr_on_o   = (seq_q.state == PWR_ON);
    assign drive_en_o = seq_q.drive;

endmodule

// File: rtl/codec_pwr_clk_ctl.sv
module codec_pwr_clk_ctl
    import codec_ctl_pkg::*;
#(
    parameter int WIN_CYCLES    = 64,
    parameter int IDLE_TIMEOUT  = 100000,
    parameter int TX_GATE_SYNCS = 2,
    parameter bit LAW_A         = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_mclk_or_pd,
    input  logic rx_bclk_or_sel,
    input  logic tx_sync,
    input  logic rx_sync,
    output logic pwr_on,
    output logic tx_drive_en,
    output logic rx_mclk_from_tx,
    output logic rx_bclk_from_tx,
    output logic mclk_div_sel
);
    typedef struct packed {
        logic tx_prev;
        logic rx_prev;
    } edge_t;

    edge_t edge_d, edge_q;
    logic  tx_rise, rx_rise;
    logic  mclk_clocked, mclk_level;
    logic  sel_clocked, sel_level;
    logic  mclk_force_off;

    always_comb begin
        edge_d         = edge_q;
        edge_d.tx_prev = tx_sync;
        edge_d.rx_prev = rx_sync;
        tx_rise        = tx_sync & ~edge_q.tx_prev;
        rx_rise        = rx_sync & ~edge_q.rx_prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= '0;
        end else begin
            edge_q <= edge_d;
        end
    end

    pin_activity_det #(.WIN(WIN_CYCLES), .EDGE_MIN(2)) u_mclk_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (rx_mclk_or_pd),
        .clocked_o (mclk_clocked),
        .level_o   (mclk_level)
    );

    pin_activity_det #(.WIN(WIN_CYCLES), .EDGE_MIN(2)) u_sel_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (rx_bclk_or_sel),
        .clocked_o (sel_clocked),
        .level_o   (sel_level)
    );

    assign mclk_force_off = ~mclk_clocked & mclk_level;

    power_seq #(.TIMEOUT(IDLE_TIMEOUT), .GATE_CNT(TX_GATE_SYNCS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_rise_i   (tx_rise),
        .rx_rise_i   (rx_rise),
        .force_off_i (mclk_force_off),
        .pwr_on_o    (pwr_on),
        .drive_en_o  (tx_drive_en)
    );

    freq_sel_decode #(.LAW_A(LAW_A)) u_div (
        .clocked_i (sel_clocked),
        .level_i   (sel_level),
        .div_sel_o (mclk_div_sel)
    );

    assign rx_mclk_from_tx = ~mclk_clocked;
    assign rx_bclk_from_tx = ~sel_clocked;

endmodule

// File: rtl/codec_pwr_clk_ctl_chk.sv
module codec_pwr_clk_ctl_chk #(
    parameter int TIMEOUT = 100000
) (
    input logic clk,
    input logic rst_n,
    input logic tx_sync,
    input logic rx_sync,
    input logic pwr_on,
    input logic tx_drive_en,
    input logic force_off
);
    logic        tx_seen_q, rx_seen_q;
    int unsigned idle_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_seen_q  <= 1'b0;
            rx_seen_q  <= 1'b0;
            idle_cnt_q <= 0;
        end else begin
            tx_seen_q <= tx_sync;
            rx_seen_q <= rx_sync;
            if ((tx_sync && !tx_seen_q) || (rx_sync && !rx_seen_q))
                idle_cnt_q <= 0;
            else if (idle_cnt_q < TIMEOUT)
                idle_cnt_q <= idle_cnt_q + 1;
        end
    end

    p_static_high_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |=> !pwr_on);

    p_wake_on_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_on) |-> $past(tx_sync || rx_sync));

    p_idle_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_on |-> (idle_cnt_q < TIMEOUT));

    p_drive_needs_power_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_drive_en |-> pwr_on);

    p_drive_on_tx_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_drive_en) |-> $past(tx_sync));

    p_drive_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_on) |-> !tx_drive_en);

endmodule

bind codec_pwr_clk_ctl codec_pwr_clk_ctl_chk #(.TIMEOUT(IDLE_TIMEOUT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_sync     (tx_sync),
    .rx_sync     (rx_sync),
    .pwr_on      (pwr_on),
    .tx_drive_en (tx_drive_en),
    .force_off   (mclk_force_off)
);

// File: tb/codec_pwr_clk_ctl_test.sv
module codec_pwr_clk_ctl_test;
    localparam int WIN = 16;
    localparam int TO  = 200;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic mpin = 1'b0, spin = 1'b0, txs = 1'b0, rxs = 1'b0;
    logic on_a, drv_a, rxm_a, rxb_a, div_a;
    logic on_m, drv_m, rxm_m, rxb_m, div_m;

    codec_pwr_clk_ctl #(.WIN_CYCLES(WIN), .IDLE_TIMEOUT(TO), .LAW_A(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .rx_mclk_or_pd(mpin), .rx_bclk_or_sel(spin),
        .tx_sync(txs), .rx_sync(rxs), .pwr_on(on_a), .tx_drive_en(drv_a),
        .rx_mclk_from_tx(rxm_a), .rx_bclk_from_tx(rxb_a), .mclk_div_sel(div_a));

    codec_pwr_clk_ctl #(.WIN_CYCLES(WIN), .IDLE_TIMEOUT(TO), .LAW_A(1'b0)) uut_mu (
        .clk(clk), .rst_n(rst_n), .rx_mclk_or_pd(mpin), .rx_bclk_or_sel(spin),
        .tx_sync(txs), .rx_sync(rxs), .pwr_on(on_m), .tx_drive_en(drv_m),
        .rx_mclk_from_tx(rxm_m), .rx_bclk_from_tx(rxb_m), .mclk_div_sel(div_m));

    int    mmode = 0, smode = 0;   // 0 low, 1 high, 2 toggle each clock, 3 toggle every 20 clocks
    string tag = "R1";
    int    checks = 0, fails = 0, cyc = 0;
    bit    done = 0;

    // behavioural reference state
    bit e_mlev, e_slev, e_mclk, e_sclk, e_txq, e_rxq, e_on, e_drv;
    int e_medg, e_sedg, e_win, e_idle, e_txcnt;

    always @(posedge clk) begin
        bit mt, st, rt, rr, force_off;
        if (!rst_n) begin
            e_mlev = 0; e_slev = 0; e_mclk = 0; e_sclk = 0; e_txq = 0; e_rxq = 0;
            e_on = 0; e_drv = 0; e_medg = 0; e_sedg = 0; e_win = 0; e_idle = 0; e_txcnt = 0;
        end else begin
            mt = mpin ^ e_mlev;
            st = spin ^ e_slev;
            rt = txs && !e_txq;
            rr = rxs && !e_rxq;
            force_off = !e_mclk && e_mlev;
            if (!e_on) begin
                if ((rt || rr) && !force_off) begin
                    e_on = 1; e_idle = 0; e_txcnt = rt ? 1 : 0;
                end
            end else if (force_off) begin
                e_on = 0; e_idle = 0; e_txcnt = 0;
            end else if (rt || rr) begin
                e_idle = 0;
                if (rt && e_txcnt < 2) e_txcnt++;
            end else if (e_idle == TO - 1) begin
                e_on = 0; e_idle = 0; e_txcnt = 0;
            end else begin
                e_idle++;
            end
            e_drv = e_on && (e_txcnt >= 2);
            if (mt && e_medg < 2) e_medg++;
            if (st && e_sedg < 2) e_sedg++;
            if (e_win == WIN - 1) begin
                e_mclk = (e_medg >= 2); e_sclk = (e_sedg >= 2);
                e_medg = 0; e_sedg = 0; e_win = 0;
            end else begin
                e_win++;
            end
            e_mlev = mpin; e_slev = spin; e_txq = txs; e_rxq = rxs;
        end
    end

    task automatic chk(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // compare every clock, then drive the dual-use pins
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!done) begin
                chk("pwr_on", on_a, e_on);
                chk("tx_drive_en", drv_a, e_drv);
                chk("rx_mclk_from_tx", rxm_a, !e_mclk);
                chk("rx_bclk_from_tx", rxb_a, !e_sclk);
                chk("mclk_div_sel A-law", div_a, e_sclk | e_slev);
                chk("mclk_div_sel mu-law", div_m, !(e_sclk | e_slev));
                chk("pwr_on mu-law", on_m, e_on);
                chk("tx_drive_en mu-law", drv_m, e_drv);
            end
            case (mmode)
                0: mpin = 1'b0;
                1: mpin = 1'b1;
                2: mpin = ~mpin;
                default: if (cyc % 20 == 0) mpin = ~mpin;
            endcase
            case (smode)
                0: spin = 1'b0;
                1: spin = 1'b1;
                2: spin = ~spin;
                default: if (cyc % 20 == 0) spin = ~spin;
            endcase
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic tx, input logic rx, input int len);
        @(negedge clk);
        txs = tx; rxs = rx;
        repeat (len) @(negedge clk);
        txs = 1'b0; rxs = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        tag = "R1";
        idle(4);
        rst_n = 1'b1;
        idle(6);
        // R4: static-low power pin, transmit sync wakes the codec
        tag = "R4";
        idle(2 * WIN);
        pulse(1, 0, 1);
        idle(4);
        // R6: second transmit sync (held for several clocks) releases the driver
        tag = "R6";
        pulse(1, 0, 5);
        idle(10);
        pulse(0, 1, 1);
        pulse(1, 0, 1);
        idle(5);
        // R5: silence on both syncs until timeout
        tag = "R5";
        idle(TO + 20);
        // R9: receive syncs wake but do not open the driver
        tag = "R9";
        pulse(0, 1, 1); idle(5);
        pulse(0, 1, 1); idle(TO - 20);
        pulse(1, 0, 1); idle(5);
        pulse(1, 0, 1); idle(5);
        // R3: static high power pin forces and holds power-down
        tag = "R3";
        mmode = 1;
        idle(3 * WIN);
        pulse(1, 1, 1); idle(5);
        pulse(1, 0, 1); idle(5);
        // R2: clocked power pin, then a pin toggling once per window
        tag = "R2";
        mmode = 2;
        idle(3 * WIN);
        pulse(1, 0, 1); idle(5);
        pulse(1, 0, 1); idle(5);
        mmode = 3;
        idle(5 * WIN);
        pulse(0, 1, 1); idle(5);
        mmode = 0;
        idle(2 * WIN);
        // R7: select pin clocked then static
        tag = "R7";
        smode = 2; idle(3 * WIN);
        smode = 0; idle(3 * WIN);
        // R8: divider decode for each pin condition
        tag = "R8";
        smode = 1; idle(3 * WIN);
        smode = 2; idle(3 * WIN);
        smode = 0; idle(3 * WIN);
        smode = 3; idle(5 * WIN);
        smode = 0; idle(2 * WIN);
        finish_run();
    end

endmodule